// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel. It moves a block of data as a series of unit transfers. Software programs four things through a small write-only register port: a requester address, a target address, a transfer count and a control word. It then arms the channel. Service begins when an armed channel sees a request, either from the hardware request pin or from a software request bit that was written through the register port. For each unit the channel drives a simple bus-master handshake. After the last bus cycle of a unit is acknowledged, it decrements the count and steps each address on its own: up, down or not at all.

There are two cycle styles. In fly-by style one bus cycle moves a unit directly between an I/O requester and a memory target. It is a memory write when data flows from requester to target, and a memory read when data flows the other way. In two-cycle style the channel issues a read at the source address and then a write at the destination address. A separate staging buffer holds the data between those two cycles. The count is loaded as N-1. The block ends when the count underflows, and it then raises a done flag and stops. A fly-by setup that is not I/O-to-memory is refused with a configuration error flag.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, bus_req_o, busy_o, done_o and cfg_err_o are all 0.
- R2: An armed channel (control bit 8 = 1) starts when drq_i is high, or after a write of bit 0 = 1 to register select 4. That software request stays pending until the block ends. With neither request present, no bus cycle is issued.
- R3: A programmed count N (register select 2) produces exactly N+1 unit transfers. done_o is then set and no further bus cycle follows.
- R4: Control bits [1:0] set the requester address step and bits [3:2] set the target address step: 0 = hold, 1 = +1, 2 = -1. Each address steps once after every unit. The base addresses are written at register selects 0 (requester) and 1 (target).
- R5: In fly-by style (control bit 7 = 1) each unit is one bus cycle at the target address with bus_mem_o = 1 and bus_flyby_o = 1. bus_wr_o = 1 when control bit 4 = 0 (requester to target), and bus_wr_o = 0 when bit 4 = 1.
- R6: In two-cycle style (bit 7 = 0) each unit is a read (bus_wr_o = 0) at the source address and then a write at the destination address. The source is the requester when bit 4 = 0 and the target when bit 4 = 1. bus_mem_o follows control bit 5 for the requester and bit 6 for the target.
- R7: If fly-by is armed and requested with a memory requester (bit 5 = 1) or an I/O target (bit 6 = 0), cfg_err_o is set and no bus cycle is issued. A write to the control register (select 3) clears the flag.
- R8: Once done_o is set, hardware and software requests are ignored until the control register is written again.
- R9: If drq_i is low at the end of a unit (and no software request is pending), the channel pauses without setting done_o. When the request returns, the channel resumes at the next count and addresses.
- R10: bus_req_o stays high with bus_addr_o unchanged until a cycle with bus_ack_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 req addr, 1 tgt addr, 2 count, 3 control, 4 soft request |
| cfg_wdata_i | input | DW | Register write data |
| drq_i | input | 1 | Hardware transfer request |
| bus_req_o | output | 1 | Bus cycle request, held until acknowledged |
| bus_addr_o | output | AW | Bus cycle address |
| bus_wr_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_mem_o | output | 1 | 1 = memory space, 0 = I/O space |
| bus_flyby_o | output | 1 | Cycle is a fly-by transfer |
| bus_ack_i | input | 1 | Bus cycle complete |
| busy_o | output | 1 | A unit transfer is in progress |
| done_o | output | 1 | Buffer transfer finished (count underflowed) |
| cfg_err_o | output | 1 | Illegal fly-by configuration was requested |

## Verification
The checker watches the bus handshake on every cycle. A pending request must keep its address until it is acknowledged. A fly-by cycle must be in memory space. No request may appear while done or the configuration error is set. An acknowledged fly-by cycle must be followed by a cycle without a request. Other behaviour shows only in the bench's scenarios, which compare every bus cycle against a scoreboard. These cover the exact number of units for a given count, the address stepping in each mode, which side is source or destination in two-cycle style, the pause and resume when the request drops, and requests being ignored after completion.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_RSVD = 2'd3
  } step_e;

  // control word bits [7:0], MSB first
  typedef struct packed {
    logic  fly;       // [7] single-cycle fly-by style
    logic  tgt_mem;   // [6] target lives in memory space
    logic  req_mem;   // [5] requester lives in memory space
    logic  dir;       // [4] 1 = target is the source
    step_e tgt_step;  // [3:2]
    step_e req_step;  // [1:0]
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int ARM_BIT = CTRL_W;

  localparam logic [2:0] SEL_REQ_ADDR = 3'd0;
  localparam logic [2:0] SEL_TGT_ADDR = 3'd1;
  localparam logic [2:0] SEL_COUNT    = 3'd2;
  localparam logic [2:0] SEL_CTRL     = 3'd3;
  localparam logic [2:0] SEL_SWREQ    = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_st_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  step_e         mode_i,
  output logic [AW-1:0] addr_o
);

  always_comb begin
    case (mode_i)
      STEP_INC: addr_o = addr_i + AW'(1);
      STEP_DEC: addr_o = addr_i - AW'(1);
      default:  addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          step_i,
  input  logic          err_i,
  input  logic [AW-1:0] req_nx_i,
  input  logic [AW-1:0] tgt_nx_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] req_addr_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic          armed_o,
  output logic          swreq_o,
  output logic          done_o,
  output logic          err_o
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o     <= '0;
      req_addr_o <= '0;
      tgt_addr_o <= '0;
      count_q    <= '0;
      armed_o    <= 1'b0;
      swreq_o    <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (step_i) begin
        req_addr_o <= req_nx_i;
        tgt_addr_o <= tgt_nx_i;
        count_q    <= count_q - CW'(1);
        if (count_q == '0) begin
          done_o  <= 1'b1;
          armed_o <= 1'b0;
          swreq_o <= 1'b0;
        end
      end
      if (err_i) begin
        err_o   <= 1'b1;
        armed_o <= 1'b0;
        swreq_o <= 1'b0;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_REQ_ADDR: req_addr_o <= wr_data[AW-1:0];
          SEL_TGT_ADDR: tgt_addr_o <= wr_data[AW-1:0];
          SEL_COUNT:    count_q    <= wr_data[CW-1:0];
          SEL_CTRL: begin
            ctrl_o  <= ctrl_t'(wr_data[CTRL_W-1:0]);
            armed_o <= wr_data[ARM_BIT];
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            swreq_o <= 1'b0;
          end
          SEL_SWREQ: if (wr_data[0] && armed_o) swreq_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic          armed_i,
  input  logic          request_i,
  input  logic          bus_ack_i,
  output logic          step_o,
  output logic          err_o,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_wr_o,
  output logic          bus_mem_o,
  output logic          bus_flyby_o,
  output logic          busy_o
);

  seq_st_e       st_q;
  logic          bad_cfg, go;
  logic [AW-1:0] src_addr, dst_addr;
  logic          src_mem, dst_mem;

  assign bad_cfg  = ctrl_i.fly & (ctrl_i.req_mem | ~ctrl_i.tgt_mem);
  assign go       = (st_q == ST_IDLE) & armed_i & request_i;
  assign err_o    = go & bad_cfg;
  assign src_addr = ctrl_i.dir ? tgt_addr_i : req_addr_i;
  assign dst_addr = ctrl_i.dir ? req_addr_i : tgt_addr_i;
  assign src_mem  = ctrl_i.dir ? ctrl_i.tgt_mem : ctrl_i.req_mem;
  assign dst_mem  = ctrl_i.dir ? ctrl_i.req_mem : ctrl_i.tgt_mem;
  assign step_o   = bus_req_o & bus_ack_i &
                    (((st_q == ST_FIRST) & bus_flyby_o) | (st_q == ST_SECOND));
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      bus_req_o   <= 1'b0;
      bus_addr_o  <= '0;
      bus_wr_o    <= 1'b0;
      bus_mem_o   <= 1'b0;
      bus_flyby_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go && !bad_cfg) begin
            st_q        <= ST_FIRST;
            bus_req_o   <= 1'b1;
            bus_flyby_o <= ctrl_i.fly;
            if (ctrl_i.fly) begin
              bus_addr_o <= tgt_addr_i;
              bus_mem_o  <= 1'b1;
              bus_wr_o   <= ~ctrl_i.dir;
            end else begin
              bus_addr_o <= src_addr;
              bus_mem_o  <= src_mem;
              bus_wr_o   <= 1'b0;
            end
          end
        end
        ST_FIRST: begin
          if (bus_ack_i) begin
            if (bus_flyby_o) begin
              bus_req_o <= 1'b0;
              st_q      <= ST_IDLE;
            end else begin
              st_q       <= ST_SECOND;
              bus_addr_o <= dst_addr;
              bus_mem_o  <= dst_mem;
              bus_wr_o   <= 1'b1;
            end
          end
        end
        ST_SECOND: begin
          if (bus_ack_i) begin
            bus_req_o <= 1'b0;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          drq_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_wr_o,
  output logic          bus_mem_o,
  output logic          bus_flyby_o,
  input  logic          bus_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_err_o
);

  localparam int NPTR = 2;  // requester and target address pointers

  ctrl_t         ctrl;
  logic [AW-1:0] req_addr, tgt_addr;
  logic          armed, swreq, step, err_set;
  logic [AW-1:0] cur_addr [NPTR];
  logic [AW-1:0] nxt_addr [NPTR];
  step_e         mode     [NPTR];

  assign cur_addr[0] = req_addr;
  assign cur_addr[1] = tgt_addr;
  assign mode[0]     = ctrl.req_step;
  assign mode[1]     = ctrl.tgt_step;

  for (genvar g = 0; g < NPTR; g++) begin : g_step
    dma_addr_step #(.AW(AW)) step_i (
      .addr_i (cur_addr[g]),
      .mode_i (mode[g]),
      .addr_o (nxt_addr[g])
    );
  end

  dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_we_i),
    .wr_sel     (cfg_sel_i),
    .wr_data    (cfg_wdata_i),
    .step_i     (step),
    .err_i      (err_set),
    .req_nx_i   (nxt_addr[0]),
    .tgt_nx_i   (nxt_addr[1]),
    .ctrl_o     (ctrl),
    .req_addr_o (req_addr),
    .tgt_addr_o (tgt_addr),
    .armed_o    (armed),
    .swreq_o    (swreq),
    .done_o     (done_o),
    .err_o      (cfg_err_o)
  );

  dma_chan_seq #(.AW(AW)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl_i      (ctrl),
    .req_addr_i  (req_addr),
    .tgt_addr_i  (tgt_addr),
    .armed_i     (armed),
    .request_i   (drq_i | swreq),
    .bus_ack_i   (bus_ack_i),
    .step_o      (step),
    .err_o       (err_set),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wr_o    (bus_wr_o),
    .bus_mem_o   (bus_mem_o),
    .bus_flyby_o (bus_flyby_o),
    .busy_o      (busy_o)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req_o,
  input logic          bus_ack_i,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_mem_o,
  input logic          bus_flyby_o,
  input logic          done_o,
  input logic          cfg_err_o
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o))); // R10

  AST_FLYBY_MEM: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_flyby_o) |-> bus_mem_o); // R5

  AST_FLYBY_ONE: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_ack_i && bus_flyby_o) |=> !bus_req_o); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bus_req_o); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> !bus_req_o); // R7

endmodule

bind dma_chan_top dma_chan_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_req_o   (bus_req_o),
  .bus_ack_i   (bus_ack_i),
  .bus_addr_o  (bus_addr_o),
  .bus_mem_o   (bus_mem_o),
  .bus_flyby_o (bus_flyby_o),
  .done_o      (done_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/dma_chan_top_tb_top.sv
`timescale 1ns/1ps
module dma_chan_top_tb_top;

  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          drq = 1'b0;
  logic          bus_ack = 1'b0;
  logic          bus_req, bus_wr, bus_mem, bus_flyby, busy, done, cfg_err;
  logic [AW-1:0] bus_addr;

  always #2 clk = ~clk;  // 250 MHz

  dma_chan_top #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .drq_i(drq), .bus_req_o(bus_req),
    .bus_addr_o(bus_addr), .bus_wr_o(bus_wr), .bus_mem_o(bus_mem),
    .bus_flyby_o(bus_flyby), .bus_ack_i(bus_ack), .busy_o(busy),
    .done_o(done), .cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic          mem;
    logic          fly;
  } bus_item_t;

  bus_item_t exp_q [$];
  string     tag_q [$];
  int checks = 0;
  int fails  = 0;
  int ack_delay = 0;
  int drop_at   = -1;
  int seen_cnt  = 0;
  int held      = 0;
  bit seen      = 0;
  logic [AW-1:0] hold_addr;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic w, input logic m,
                      input logic f, input string tag);
    bus_item_t it;
    it.addr = a; it.wr = w; it.mem = m; it.fly = f;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done == 1'b1, tag, "done_o after buffer", longint'(done), 1);
    check(exp_q.size() == 0, tag, "outstanding expected cycles", exp_q.size(), 0);
  endtask

  // monitor / responder: compare each new bus cycle against the scoreboard
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; seen = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (!seen) begin
        seen = 1; held = 0; hold_addr = bus_addr;
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected bus cycle addr", bus_addr, 0);
        end else begin
          bus_item_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({bus_addr, bus_wr, bus_mem, bus_flyby} == e, t,
                "bus cycle {addr,wr,mem,fly}",
                {bus_addr, bus_wr, bus_mem, bus_flyby}, e);
        end
      end else begin
        check(bus_addr == hold_addr, "R10", "address held while waiting",
              bus_addr, hold_addr);
      end
      if (held >= ack_delay) begin
        bus_ack = 1'b1; seen = 0; seen_cnt++;
        if (seen_cnt == drop_at) drq = 1'b0;
      end else held++;
    end
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_req == 0, "R1", "bus_req_o in reset", bus_req, 0);
    check(busy == 0, "R1", "busy_o in reset", busy, 0);
    check(done == 0, "R1", "done_o in reset", done, 0);
    check(cfg_err == 0, "R1", "cfg_err_o in reset", cfg_err, 0);
    @(negedge clk); rst = 1'b0;

    // fly-by, requester->memory, target +1, count 2 -> 3 writes (R3, R5, R2 soft)
    wr_reg(3'd0, 32'h0050);
    wr_reg(3'd1, 32'h0100);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'h1C4);
    for (int i = 0; i < 3; i++) push(AW'(16'h0100 + i), 1'b1, 1'b1, 1'b1, "R5");
    wr_reg(3'd4, 32'h1);
    wait_done("R3");

    // after done, requests are ignored (R8)
    drq = 1'b1;
    wr_reg(3'd4, 32'h1);
    begin
      int hits = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_req) hits++; end
      check(hits == 0, "R8", "bus cycles after done", hits, 0);
      check(done == 1, "R8", "done_o held", done, 1);
    end
    drq = 1'b0;

    // two-cycle, target(mem,-1) -> requester(io,+1), hw request, slow ack (R6, R4, R10)
    ack_delay = 2;
    wr_reg(3'd0, 32'h0010);
    wr_reg(3'd1, 32'h0200);
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd3, 32'h159);
    push(16'h0200, 1'b0, 1'b1, 1'b0, "R6");
    push(16'h0010, 1'b1, 1'b0, 1'b0, "R6");
    push(16'h01FF, 1'b0, 1'b1, 1'b0, "R4");
    push(16'h0011, 1'b1, 1'b0, 1'b0, "R4");
    drq = 1'b1;
    wait_done("R6");
    drq = 1'b0;
    ack_delay = 0;

    // fly-by read from memory, target hold (R4, R5)
    wr_reg(3'd1, 32'h0300);
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd3, 32'h1D0);
    push(16'h0300, 1'b0, 1'b1, 1'b1, "R4");
    push(16'h0300, 1'b0, 1'b1, 1'b1, "R5");
    wr_reg(3'd4, 32'h1);
    wait_done("R4");

    // illegal fly-by: memory requester (R7)
    wr_reg(3'd3, 32'h1E0);
    wr_reg(3'd4, 32'h1);
    repeat (4) @(negedge clk);
    check(cfg_err == 1, "R7", "cfg_err_o on bad fly-by", cfg_err, 1);
    check(busy == 0, "R7", "no transfer on bad fly-by", busy, 0);
    wr_reg(3'd3, 32'h0);
    check(cfg_err == 0, "R7", "cfg_err_o cleared by control write", cfg_err, 0);

    // armed, no request -> idle (R2); then pause / resume (R9)
    wr_reg(3'd1, 32'h0400);
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd3, 32'h1C4);
    begin
      int hits = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (bus_req) hits++; end
      check(hits == 0, "R2", "bus cycles without request", hits, 0);
    end
    for (int i = 0; i < 4; i++) push(AW'(16'h0400 + i), 1'b1, 1'b1, 1'b1, "R9");
    seen_cnt = 0; drop_at = 1;
    drq = 1'b1;
    begin
      int hits = 0;
      int n = 0;
      while (seen_cnt < 1 && n < 100) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_req) hits++; end
      check(hits == 0, "R9", "bus cycles while paused", hits, 0);
      check(done == 0, "R9", "done_o while paused", done, 0);
      check(exp_q.size() == 3, "R9", "units left while paused", exp_q.size(), 3);
    end
    drop_at = -1;
    drq = 1'b1;
    wait_done("R9");
    drq = 1'b0;

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule